// File: doc/BRIEF.md
# SIMT Divergence and Reconvergence Controller

This block keeps the control state of one 32-lane warp that runs under a single shared program counter. It holds the warp PC and a lane-enable mask. A lane whose mask bit is clear sits out the instruction at the current PC. When the front end reports a conditional branch with a per-lane predicate, the block compares the predicate with the current mask. If all enabled lanes agree, the warp jumps as one. If they disagree, the block runs the taken lanes first. It then runs the not-taken lanes. Finally it restores the combined lane set at the reconvergence address.

Pending work is held in a small frame stack. The current frame (PC, mask, merge address) lives in registers. A divergent branch saves two frames below it: first the merge frame, which holds the mask from before the split, then the not-taken frame. Whenever the stack is non-empty and the current PC equals the current merge address, the lanes have reached the join. That cycle goes to popping one frame, and no lane moves past the join until the frame that restores the full group has been popped. Nesting uses two slots per level. A divergent branch that does not fit sets a sticky error and leaves the warp unchanged.

Top module: `simt_reconv_unit`

## Requirements
- R1: During and right after reset, `warp_pc` equals the parameter `RESET_PC` (default 0x100), `active_mask` is all ones and `stack_overflow` is 0.
- R2: A cycle with `pc_adv` high, no branch and no pending join adds `PC_STEP` (default 4) to `warp_pc` and keeps the mask. A cycle with no input event and no join changes nothing.
- R3: A branch whose predicate is set for every enabled lane loads `br_target` in the next cycle, keeps the mask, and saves no frame. Reaching `br_reconv` later therefore changes nothing.
- R4: A branch whose predicate is clear for every enabled lane loads `br_fallthru`, keeps the mask, and saves no frame. This also applies when only some lanes are enabled.
- R5: A divergent branch sets `warp_pc` to `br_target` and `active_mask` to `br_pred & active_mask` in the next cycle.
- R6: When `warp_pc` equals the current merge address and a frame is saved, the next cycle loads the not-taken frame: `br_fallthru` with mask `~br_pred & old_mask`.
- R7: When the not-taken side reaches the merge address, the next cycle keeps `warp_pc` at that address and restores the mask from before the split.
- R8: In a join cycle (R6, R7), `pc_adv` and `br_valid` are ignored.
- R9: Branches nest. An inner split inside a taken path comes back first to the outer taken mask and then to the outer full mask.
- R10: A divergent branch that arrives with fewer than two free slots (`DEPTH` default 4) sets `stack_overflow` and leaves `warp_pc` and `active_mask` unchanged.
- R11: `stack_overflow` stays set until reset.
- R12: A predicate taken from bit 2 of the lane index gives a taken mask of 0xF0F0F0F0 from a full warp and 0x0F0F0F0F for the other side.
- R13: When `br_valid` and `pc_adv` arrive in the same cycle, the branch wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Branch event this cycle |
| br_pred | input | 32 | Per-lane branch outcome, 1 = taken |
| br_target | input | 32 | Taken-path address |
| br_fallthru | input | 32 | Not-taken-path address |
| br_reconv | input | 32 | Merge address of this branch |
| pc_adv | input | 1 | Step the PC to the next instruction |
| warp_pc | output | 32 | Shared warp program counter |
| active_mask | output | 32 | Lanes enabled at `warp_pc` |
| stack_overflow | output | 1 | Sticky frame-stack overflow flag |

## Verification
A wrong frame order, a lost push or a bad stack count shows up at the ports. It appears one cycle after the PC reaches a merge address: either the wrong address and lane set load, or no join happens and the PC keeps stepping past the merge point. A mask computed from the wrong lanes appears on `active_mask` in the cycle right after the branch. A missed ignore in a join cycle shows as a PC that moved by one step. The stimulus walks a nested divergence out to both merges, so each of these errors changes a sampled value within one or two cycles of its cause.

// File: rtl/simt_reconv_pkg.sv
package simt_reconv_pkg;
  localparam int LANES = 32;
  localparam int PC_W  = 32;

  typedef logic [LANES-1:0] lane_mask_t;
  typedef logic [PC_W-1:0]  pc_t;

  typedef struct packed {
    pc_t        pc;
    lane_mask_t mask;
    pc_t        rpc;
  } frame_t;

  function automatic pc_t pc_step(pc_t cur, pc_t step);
    return cur + step;
  endfunction

  // lanes whose index has bit b set
  function automatic lane_mask_t lane_bit_select(int unsigned b);
    lane_mask_t m;
    for (int i = 0; i < LANES; i++) m[i] = ((i >> b) & 1) != 0;
    return m;
  endfunction
endpackage

// File: rtl/simt_branch_split.sv
module simt_branch_split
  import simt_reconv_pkg::*;
(
  input  lane_mask_t cur_mask,
  input  lane_mask_t pred,
  output lane_mask_t taken,
  output lane_mask_t not_taken,
  output logic       all_taken,
  output logic       none_taken,
  output logic       divergent
);
  always_comb begin
    taken      = pred & cur_mask;
    not_taken  = ~pred & cur_mask;
    all_taken  = (not_taken == '0);
    none_taken = (taken == '0);
    divergent  = !all_taken && !none_taken;
  end
endmodule

// File: rtl/simt_frame_stack.sv
module simt_frame_stack
  import simt_reconv_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_pair,
  input  frame_t           push_lo,
  input  frame_t           push_hi,
  input  logic             pop,
  output frame_t           top,
  output logic [CNT_W-1:0] count,
  output logic             room_pair
);
  frame_t slot [DEPTH];

  assign room_pair = (32'(count) + 2) <= DEPTH;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic wr_lo, wr_hi;
    assign wr_lo = push_pair && (32'(count) == s);
    assign wr_hi = push_pair && (32'(count) + 1 == s);
    always_ff @(posedge clk) begin
      if (!rst_n)     slot[s] <= '0;
      else if (wr_lo) slot[s] <= push_lo;
      else if (wr_hi) slot[s] <= push_hi;
    end
  end

  always_comb begin
    top = '0;
    for (int s = 0; s < DEPTH; s++)
      if (32'(count) == s + 1) top = slot[s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    count <= '0;
    else if (push_pair)            count <= count + CNT_W'(2);
    else if (pop && count != '0)   count <= count - CNT_W'(1);
  end
endmodule

// File: rtl/simt_reconv_unit.sv
module simt_reconv_unit
  import simt_reconv_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0100,
  parameter logic [31:0] PC_STEP  = 32'd4,
  parameter int          DEPTH    = 4,
  localparam int         CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        br_valid,
  input  logic [31:0] br_pred,
  input  logic [31:0] br_target,
  input  logic [31:0] br_fallthru,
  input  logic [31:0] br_reconv,
  input  logic        pc_adv,
  output logic [31:0] warp_pc,
  output logic [31:0] active_mask,
  output logic        stack_overflow
);
  pc_t        cur_pc, cur_rpc;
  lane_mask_t cur_mask;
  logic       err_q;

  lane_mask_t taken, not_taken;
  logic       all_taken, none_taken, divergent;

  frame_t           top_frame, push_lo, push_hi;
  logic [CNT_W-1:0] stack_depth;
  logic             room_pair;

  // named internal events
  logic at_reconv, do_branch, do_diverge, overflow_hit, do_step;

  simt_branch_split u_split (
    .cur_mask   (cur_mask),
    .pred       (br_pred),
    .taken      (taken),
    .not_taken  (not_taken),
    .all_taken  (all_taken),
    .none_taken (none_taken),
    .divergent  (divergent)
  );

  assign at_reconv    = (stack_depth != '0) && (cur_pc == cur_rpc);
  assign do_branch    = br_valid && !at_reconv;
  assign do_diverge   = do_branch && divergent && room_pair;
  assign overflow_hit = do_branch && divergent && !room_pair;
  assign do_step      = pc_adv && !br_valid && !at_reconv;

  assign push_lo = '{pc: br_reconv,   mask: cur_mask,  rpc: cur_rpc};
  assign push_hi = '{pc: br_fallthru, mask: not_taken, rpc: br_reconv};

  simt_frame_stack #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_pair (do_diverge),
    .push_lo   (push_lo),
    .push_hi   (push_hi),
    .pop       (at_reconv),
    .top       (top_frame),
    .count     (stack_depth),
    .room_pair (room_pair)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_pc   <= RESET_PC;
      cur_mask <= '1;
      cur_rpc  <= '1;
      err_q    <= 1'b0;
    end else begin
      if (overflow_hit) err_q <= 1'b1;
      if (at_reconv) begin
        cur_pc   <= top_frame.pc;
        cur_mask <= top_frame.mask;
        cur_rpc  <= top_frame.rpc;
      end else if (do_branch) begin
        if (do_diverge) begin
          cur_pc   <= br_target;
          cur_mask <= taken;
          cur_rpc  <= br_reconv;
        end else if (!divergent) begin
          cur_pc <= all_taken ? br_target : br_fallthru;
        end
      end else if (do_step) begin
        cur_pc <= pc_step(cur_pc, PC_STEP);
      end
    end
  end

  assign warp_pc        = cur_pc;
  assign active_mask    = cur_mask;
  assign stack_overflow = err_q;
endmodule

// File: rtl/simt_reconv_sva.sv
module simt_reconv_sva #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             br_valid,
  input logic             pc_adv,
  input logic [31:0]      br_pred,
  input logic [31:0]      warp_pc,
  input logic [31:0]      active_mask,
  input logic             stack_overflow,
  input logic             at_reconv,
  input logic [CNT_W-1:0] stack_depth
);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid && !pc_adv && !at_reconv) |=> ($stable(warp_pc) && $stable(active_mask)));

  a_r5_mask_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !at_reconv) |=> ((active_mask & ~$past(active_mask)) == 32'd0));

  a_r3_uniform_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !at_reconv && ((br_pred & active_mask) == active_mask)) |=> $stable(stack_depth));

  a_r6_join_pops: assert property (@(posedge clk) disable iff (!rst_n)
    at_reconv |=> (32'(stack_depth) + 1 == 32'($past(stack_depth))));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    32'(stack_depth) <= DEPTH);

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stack_overflow |=> stack_overflow);

  a_r5_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    active_mask != 32'd0);
endmodule

bind simt_reconv_unit simt_reconv_sva #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_sva (
  .clk            (clk),
  .rst_n          (rst_n),
  .br_valid       (br_valid),
  .pc_adv         (pc_adv),
  .br_pred        (br_pred),
  .warp_pc        (warp_pc),
  .active_mask    (active_mask),
  .stack_overflow (stack_overflow),
  .at_reconv      (at_reconv),
  .stack_depth    (stack_depth)
);

// File: tb/simt_reconv_unit_bench.sv
module simt_reconv_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0;
  logic [31:0] br_pred = '0, br_target = '0, br_fallthru = '0, br_reconv = '0;
  logic        pc_adv = 1'b0;
  logic [31:0] warp_pc, active_mask;
  logic        stack_overflow;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk; // 125 MHz

  simt_reconv_unit u_simt_reconv_unit (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_pred(br_pred),
    .br_target(br_target), .br_fallthru(br_fallthru), .br_reconv(br_reconv),
    .pc_adv(pc_adv), .warp_pc(warp_pc), .active_mask(active_mask),
    .stack_overflow(stack_overflow)
  );

  typedef struct packed {
    logic        br;
    logic        adv;
    logic [31:0] pred;
    logic [31:0] tgt;
    logic [31:0] ft;
    logic [31:0] rc;
    logic [31:0] e_pc;
    logic [31:0] e_mask;
    logic        e_err;
  } vec_t;

  localparam logic [31:0] FULL = 32'hFFFF_FFFF;
  localparam logic [31:0] HI4  = 32'hF0F0_F0F0; // lanes with index bit 2 set
  localparam logic [31:0] LO4  = 32'h0F0F_0F0F;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,32'h0,        32'h0,  32'h0,  32'h0,  32'h104,FULL,          1'b0}, // R2 step
    '{1'b0,1'b0,32'h0,        32'h0,  32'h0,  32'h0,  32'h104,FULL,          1'b0}, // R2 hold
    '{1'b1,1'b0,FULL,         32'h200,32'h108,32'h300,32'h200,FULL,          1'b0}, // R3 uniform taken
    '{1'b1,1'b0,32'h0,        32'h400,32'h204,32'h208,32'h204,FULL,          1'b0}, // R4 uniform not taken
    '{1'b0,1'b1,32'h0,        32'h0,  32'h0,  32'h0,  32'h208,FULL,          1'b0}, // R3/R4 no frame at 0x208
    '{1'b0,1'b1,32'h0,        32'h0,  32'h0,  32'h0,  32'h20C,FULL,          1'b0}, // R2
    '{1'b1,1'b1,HI4,          32'h500,32'h210,32'h600,32'h500,HI4,           1'b0}, // R5 R12 R13
    '{1'b1,1'b0,32'h0000_FFFF,32'h700,32'h504,32'h508,32'h700,32'h0000_F0F0, 1'b0}, // R9 nested
    '{1'b1,1'b0,32'h0000_00F0,32'h800,32'h704,32'h70C,32'h700,32'h0000_F0F0, 1'b1}, // R10 overflow
    '{1'b1,1'b0,FULL,         32'h508,32'h704,32'h0,  32'h508,32'h0000_F0F0, 1'b1}, // R11 sticky
    '{1'b0,1'b1,32'h0,        32'h0,  32'h0,  32'h0,  32'h504,32'hF0F0_0000, 1'b1}, // R6 R8 adv ignored
    '{1'b0,1'b1,32'h0,        32'h0,  32'h0,  32'h0,  32'h508,32'hF0F0_0000, 1'b1}, // R2
    '{1'b1,1'b0,32'h0000_000F,32'h900,32'h50C,32'hA00,32'h508,HI4,           1'b1}, // R7 R8 R9 branch ignored
    '{1'b0,1'b0,32'h0,        32'h0,  32'h0,  32'h0,  32'h508,HI4,           1'b1}, // R2 hold
    '{1'b1,1'b0,FULL,         32'h600,32'h50C,32'h0,  32'h600,HI4,           1'b1}, // R3
    '{1'b0,1'b0,32'h0,        32'h0,  32'h0,  32'h0,  32'h210,LO4,           1'b1}, // R6 R12 other side
    '{1'b1,1'b0,HI4,          32'h900,32'h600,32'h0,  32'h600,LO4,           1'b1}, // R4 partial mask
    '{1'b0,1'b0,32'h0,        32'h0,  32'h0,  32'h0,  32'h600,FULL,          1'b1}, // R7 R9 full merge
    '{1'b0,1'b1,32'h0,        32'h0,  32'h0,  32'h0,  32'h604,FULL,          1'b1}  // R2 stack empty
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic b, logic a, logic [31:0] p, logic [31:0] t,
                       logic [31:0] f, logic [31:0] r);
    @(negedge clk);
    br_valid = b; pc_adv = a; br_pred = p;
    br_target = t; br_fallthru = f; br_reconv = r;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 pc in reset", warp_pc, 32'h100);
    check("R1 mask in reset", active_mask, FULL);
    check("R1 err in reset", {31'd0, stack_overflow}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].br, TBL[i].adv, TBL[i].pred, TBL[i].tgt, TBL[i].ft, TBL[i].rc);
      check($sformatf("row %0d pc", i), warp_pc, TBL[i].e_pc);
      check($sformatf("row %0d mask", i), active_mask, TBL[i].e_mask);
      check($sformatf("row %0d err", i), {31'd0, stack_overflow}, {31'd0, TBL[i].e_err});
    end

    // R1 / R11: reset clears the sticky flag
    @(negedge clk); rst_n = 1'b0; br_valid = 1'b0; pc_adv = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 pc after reset", warp_pc, 32'h100);
    check("R1 mask after reset", active_mask, FULL);
    check("R11 err cleared by reset", {31'd0, stack_overflow}, 32'd0);

    // R5/R6: taken target equals the merge address, cascade of joins
    drive(1'b1, 1'b0, HI4, 32'h180, 32'h17C, 32'h180);
    check("R5 pc", warp_pc, 32'h180);
    check("R5 mask", active_mask, HI4);
    drive(1'b0, 1'b1, 32'h0, 32'h0, 32'h0, 32'h0);
    check("R6 R8 pc to other side", warp_pc, 32'h17C);
    check("R6 mask other side", active_mask, LO4);
    drive(1'b0, 1'b1, 32'h0, 32'h0, 32'h0, 32'h0);
    check("R2 step to merge", warp_pc, 32'h180);
    drive(1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0);
    check("R7 pc at merge", warp_pc, 32'h180);
    check("R7 mask restored", active_mask, FULL);
    drive(1'b0, 1'b1, 32'h0, 32'h0, 32'h0, 32'h0);
    check("R2 step after merge", warp_pc, 32'h184);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule